// File: doc/BRIEF.md
# Six-Button Gamepad Select Multiplexer

This block stands in for a game controller that hands its buttons to a host through a six-bit, active-low group. The host selects which buttons it sees through one select level. In the basic mode that level picks one of two fixed groups. In the extended mode a small phase counter steps on every low-to-high change of the select level. Certain phases swap in the four extra buttons, a marker pattern of zeros, or a marker pattern of ones, so a host that knows the sequence can read all twelve buttons.

The host updates the select level with a one-cycle write strobe that carries the new level. Each write also restarts an idle counter. The idle counter advances on a free-running tick input. If the host stays quiet for `IDLE_TICKS` ticks, the phase goes back to zero. The button inputs are plain active-high levels, one per button. The output is combinational from the registered select level and phase, together with the live buttons. There is no handshake at either edge, because every pin is a control level or a strobe.

Top module: `pad6_mux`

## Requirements
- R1: The output is active-low, so a pressed button reads 0. The bits of the `btn` input are Up=0, Down=1, Left=2, Right=3, A=4, B=5, C=6, Start=7, X=8, Y=9, Z=10, Mode=11.
- R2: In a normal encoding with the select level high, `pad_n[5:0]` is {C, B, Right, Left, Down, Up}.
- R3: In a normal encoding with the select level low, `pad_n[5:0]` is {Start, A, 0, 0, Down, Up}.
- R4: A write that moves the select level from 0 to 1 increments the phase. The phase holds at 3 once it reaches 3. A write that does not raise the level leaves the phase unchanged.
- R5: In extended mode, phase 2 with the select level low gives {Start, A, 0, 0, 0, 0}.
- R6: In extended mode, phase 3 with the select level high gives {C, B, Mode, X, Y, Z}.
- R7: In extended mode, phase 3 with the select level low gives {Start, A, 1, 1, 1, 1}.
- R8: In basic mode (`six_mode`=0) the phase has no effect on the output, and only the R2/R3 encodings appear.
- R9: After `IDLE_TICKS` ticks with no write, the phase returns to 0 in the cycle after the last tick. After `IDLE_TICKS`-1 such ticks it is unchanged.
- R10: Every write restarts the idle count from zero.
- R11: When a write and the expiring tick fall in the same cycle, the write wins. The phase advances or holds as in R4, and the idle count restarts.
- R12: A synchronous reset sets the phase to 0, the select level to 1 and the idle count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn | input | 12 | Button levels, active high (order in R1) |
| six_mode | input | 1 | 1 = extended six-button mode, 0 = basic mode |
| host_wr | input | 1 | One-cycle strobe: host writes a new select level |
| host_sel | input | 1 | Select level that goes with `host_wr` |
| tick | input | 1 | Idle-timeout time base, one cycle per tick |
| pad_n | output | 6 | Active-low button group |

## Verification
Two functions can fall in the same cycle: a select write that raises the level, and the tick that would end the idle window. Both change the phase, and in opposite directions. The bench lets the idle count reach one short of its limit. It then issues a rising write together with a tick. The expected result is the advanced phase, which is judged through the next low and high reads in extended mode. A further check confirms that the idle window has restarted in full.

// File: rtl/pad6_pkg.sv
package pad6_pkg;
  localparam int BTN_N  = 12;
  localparam int PAD_W  = 6;
  localparam int B_UP   = 0;
  localparam int B_DN   = 1;
  localparam int B_LT   = 2;
  localparam int B_RT   = 3;
  localparam int B_A    = 4;
  localparam int B_B    = 5;
  localparam int B_C    = 6;
  localparam int B_ST   = 7;
  localparam int B_X    = 8;
  localparam int B_Y    = 9;
  localparam int B_Z    = 10;
  localparam int B_MD   = 11;
  localparam int PH_W   = 2;
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_TOP = phase_t'(2'd3);
  localparam phase_t PH_ZRO = phase_t'(2'd2);
endpackage

// File: rtl/pad6_phase.sv
module pad6_phase
  import pad6_pkg::*;
#(
  parameter int IDLE_TICKS = 1000,
  localparam int CW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          sel_d,
  input  logic          tick,
  output logic          sel_q,
  output phase_t        phase_q,
  output logic [CW-1:0] idle_q
);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);

  logic rise;
  logic expire;

  assign rise   = wr && !sel_q && sel_d;
  assign expire = tick && (idle_q == IDLE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b1;
      phase_q <= '0;
      idle_q  <= '0;
    end else if (wr) begin
      sel_q  <= sel_d;
      idle_q <= '0;
      if (rise && phase_q != PH_TOP)
        phase_q <= phase_t'(phase_q + 1'b1);
    end else if (tick) begin
      if (expire) begin
        phase_q <= '0;
        idle_q  <= '0;
      end else begin
        idle_q  <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pad6_encode.sv
module pad6_encode
  import pad6_pkg::*;
(
  input  logic [BTN_N-1:0] btn,
  input  logic             six_mode,
  input  logic             sel,
  input  phase_t           phase,
  output logic [PAD_W-1:0] pad_n
);
  logic [BTN_N-1:0] p;
  logic [PAD_W-1:0] hi_grp;
  logic [PAD_W-1:0] lo_grp;
  logic [PAD_W-1:0] ext_hi;
  logic [PAD_W-1:0] ext_lo_z;
  logic [PAD_W-1:0] ext_lo_o;

  assign p        = ~btn;
  assign hi_grp   = {p[B_C], p[B_B], p[B_RT], p[B_LT], p[B_DN], p[B_UP]};
  assign lo_grp   = {p[B_ST], p[B_A], 2'b00, p[B_DN], p[B_UP]};
  assign ext_hi   = {p[B_C], p[B_B], p[B_MD], p[B_X], p[B_Y], p[B_Z]};
  assign ext_lo_z = {p[B_ST], p[B_A], 4'b0000};
  assign ext_lo_o = {p[B_ST], p[B_A], 4'b1111};

  always_comb begin
    pad_n = sel ? hi_grp : lo_grp;
    if (six_mode) begin
      if (phase == PH_TOP)
        pad_n = sel ? ext_hi : ext_lo_o;
      else if (phase == PH_ZRO && !sel)
        pad_n = ext_lo_z;
    end
  end
endmodule

// File: rtl/pad6_mux.sv
module pad6_mux
  import pad6_pkg::*;
#(
  parameter int IDLE_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_N-1:0] btn,
  input  logic             six_mode,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic             tick,
  output logic [PAD_W-1:0] pad_n
);
  localparam int CW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;

  logic          sel_q;
  phase_t        phase_q;
  logic [CW-1:0] idle_q;

  pad6_phase #(.IDLE_TICKS(IDLE_TICKS)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .wr      (host_wr),
    .sel_d   (host_sel),
    .tick    (tick),
    .sel_q   (sel_q),
    .phase_q (phase_q),
    .idle_q  (idle_q)
  );

  pad6_encode u_enc (
    .btn      (btn),
    .six_mode (six_mode),
    .sel      (sel_q),
    .phase    (phase_q),
    .pad_n    (pad_n)
  );
endmodule

// File: rtl/pad6_mux_chk.sv
module pad6_mux_chk
  import pad6_pkg::*;
#(
  parameter int IDLE_TICKS = 1000,
  localparam int CW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             six_mode,
  input logic             host_wr,
  input logic             host_sel,
  input logic             tick,
  input logic             sel_q,
  input phase_t           phase_q,
  input logic [CW-1:0]    idle_q,
  input logic [PAD_W-1:0] pad_n
);
  a_r4_rise_step: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel && !sel_q && phase_q != PH_TOP) |=> phase_q == $past(phase_q) + 2'd1);

  a_r4_hold_top: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TOP && host_wr) |=> phase_q == PH_TOP);

  a_r9_timeout: assert property (@(posedge clk) disable iff (rst)
    (tick && !host_wr && idle_q == CW'(IDLE_TICKS - 1)) |=> phase_q == '0);

  a_r10_wr_restart: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> idle_q == '0);

  a_r3_low_gap: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && !(six_mode && phase_q == PH_TOP)) |-> pad_n[3:2] == 2'b00);

  a_r7_ones: assert property (@(posedge clk) disable iff (rst)
    (six_mode && !sel_q && phase_q == PH_TOP) |-> pad_n[3:0] == 4'hF);
endmodule

bind pad6_mux pad6_mux_chk #(.IDLE_TICKS(IDLE_TICKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .six_mode (six_mode),
  .host_wr  (host_wr),
  .host_sel (host_sel),
  .tick     (tick),
  .sel_q    (sel_q),
  .phase_q  (phase_q),
  .idle_q   (idle_q),
  .pad_n    (pad_n)
);

// File: tb/pad6_mux_tb.sv
module pad6_mux_tb;
  localparam int LIM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] btn = '0;
  logic        six_mode = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b1;
  logic        tick = 1'b0;
  logic [5:0]  pad_n;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [5:0] val; string tag; } exp_t;
  exp_t q[$];

  int m_ph = 0;
  int m_idle = 0;
  logic m_sel = 1'b1;

  always #4 clk = ~clk;

  pad6_mux #(.IDLE_TICKS(LIM)) u_dut (
    .clk(clk), .rst(rst), .btn(btn), .six_mode(six_mode),
    .host_wr(host_wr), .host_sel(host_sel), .tick(tick), .pad_n(pad_n)
  );

  function automatic logic [5:0] model(input logic [11:0] b, input logic six,
                                       input int ph, input logic s);
    logic [11:0] p;
    p = ~b;
    if (six && ph == 3)
      return s ? {p[6], p[5], p[11], p[8], p[9], p[10]} : {p[7], p[4], 4'hF};
    if (six && ph == 2 && !s)
      return {p[7], p[4], 4'h0};
    return s ? {p[6], p[5], p[3], p[2], p[1], p[0]} : {p[7], p[4], 2'b00, p[1], p[0]};
  endfunction

  task automatic step(input logic wr, input logic sv, input logic tk,
                      input logic [11:0] b, input logic six, input string tag);
    @(negedge clk);
    host_wr = wr; host_sel = sv; tick = tk; btn = b; six_mode = six;
    if (wr) begin
      m_idle = 0;
      if (!m_sel && sv && m_ph != 3) m_ph++;
      m_sel = sv;
    end else if (tk) begin
      if (m_idle == LIM - 1) begin m_ph = 0; m_idle = 0; end
      else m_idle++;
    end
    @(posedge clk);
    #1;
    host_wr = 1'b0; tick = 1'b0;
    q.push_back('{model(b, six, m_ph, m_sel), tag});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pad_n !== e.val) begin
          errors++;
          $display("FAIL %s: pad_n=%b expected %b", e.tag, pad_n, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    btn = 12'h0A5;
    #1;
    checks++;
    if (pad_n !== model(12'h0A5, 1'b0, 0, 1'b1)) begin
      errors++;
      $display("FAIL R12: pad_n=%b expected %b", pad_n, model(12'h0A5, 1'b0, 0, 1'b1));
    end
    // R1 R2 R3: basic mode, several patterns
    step(1, 1, 0, 12'h000, 0, "R2");
    step(1, 1, 0, 12'h06F, 0, "R1");
    step(1, 0, 0, 12'h093, 0, "R3");
    step(1, 0, 0, 12'hFFF, 0, "R3");
    step(1, 1, 0, 12'h05A, 0, "R2");
    // drive phase to 2 in extended mode (phase now 1 after last rise)
    step(1, 0, 0, 12'h0F0, 1, "R4");
    step(1, 1, 0, 12'h0F0, 1, "R4");
    step(1, 0, 0, 12'h090, 1, "R5");
    step(1, 0, 0, 12'h01F, 1, "R5");
    step(1, 1, 0, 12'hA40, 1, "R6");
    step(1, 1, 0, 12'h5A0, 1, "R6");
    step(1, 0, 0, 12'h080, 1, "R7");
    step(1, 1, 0, 12'h300, 1, "R4");
    step(1, 0, 0, 12'h010, 1, "R4");
    // R8: phase 3, basic mode shows normal groups
    step(0, 0, 0, 12'hF93, 0, "R8");
    step(1, 1, 0, 12'hF6C, 0, "R8");
    // R9: ticks up to timeout, phase read in extended mode
    for (int i = 0; i < LIM - 1; i++) step(0, 1, 1, 12'hF00, 1, "R9");
    step(0, 1, 0, 12'hF00, 1, "R9");
    step(0, 1, 1, 12'hF00, 1, "R9");
    step(1, 0, 0, 12'h0FF, 1, "R9");
    // R10: write in the middle restarts the window
    step(1, 1, 0, 12'h000, 1, "R10");
    step(1, 0, 0, 12'h000, 1, "R10");
    step(1, 1, 0, 12'h000, 1, "R10");
    for (int i = 0; i < LIM - 2; i++) step(0, 1, 1, 12'h0C0, 1, "R10");
    step(1, 1, 0, 12'h0C0, 1, "R10");
    for (int i = 0; i < LIM - 2; i++) step(0, 1, 1, 12'h0C0, 1, "R10");
    step(1, 0, 0, 12'h0C0, 1, "R10");
    // R11: rising write together with expiring tick
    for (int i = 0; i < LIM - 1; i++) step(0, 0, 1, 12'h111, 1, "R11");
    step(1, 1, 1, 12'h222, 1, "R11");
    step(1, 0, 0, 12'h0B0, 1, "R11");
    for (int i = 0; i < LIM - 1; i++) step(0, 0, 1, 12'h0B0, 1, "R11");
    step(1, 0, 0, 12'h0B0, 1, "R11");
    // R12: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_ph = 0; m_idle = 0; m_sel = 1'b1;
    step(1, 0, 0, 12'h011, 1, "R12");
    step(0, 0, 0, 12'h011, 1, "R12");
    repeat (2) @(posedge clk);
    #4;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule